// File: doc/BRIEF.md
# Packed SIMD Halfword/Byte Adder

This block performs lane-wise modular addition and subtraction on two 32-bit operand words. The word splits either into two independent 16-bit lanes or into four independent 8-bit lanes, and no carry or borrow crosses a lane boundary. Two exchange operations pair the upper half of the first operand with the lower half of the second operand, and the lower half of the first operand with the upper half of the second. One lane of the pair adds and the other subtracts.

Each lane also reports a greater-or-equal flag. In unsigned mode the flag is the lane's carry-out for an add and the absence of a borrow for a subtract. In signed mode the flag shows that the exact, unwrapped lane result is not negative. The flags sit in a 4-bit vector with one bit per byte position. A 16-bit lane writes its flag to both bits of the bytes it covers. The result, the flags and a valid strobe are registered, so they appear one cycle after an accepted input.

Top module: `simd_pack_adder`

## Requirements
- R1: Halfword add (op code 00, `in_byte`=0) gives result[31:16] = A[31:16]+B[31:16] and result[15:0] = A[15:0]+B[15:0]. Each sum is taken modulo 2^16, and no carry passes from the low lane to the high lane.
- R2: Halfword subtract (op code 01, `in_byte`=0) gives result[31:16] = A[31:16]-B[31:16] and result[15:0] = A[15:0]-B[15:0]. Each difference is taken modulo 2^16.
- R3: Byte add (op code 00, `in_byte`=1) adds each of the byte lanes [7:0], [15:8], [23:16] and [31:24] independently, modulo 2^8.
- R4: Byte subtract (op code 01, `in_byte`=1) subtracts each byte lane independently, modulo 2^8.
- R5: Exchange add-subtract (op code 10) gives high = A[31:16]+B[15:0] and low = A[15:0]-B[31:16]. It always uses 16-bit lanes, whatever the value of `in_byte`.
- R6: Exchange subtract-add (op code 11) gives high = A[31:16]-B[15:0] and low = A[15:0]+B[31:16]. It always uses 16-bit lanes, whatever the value of `in_byte`.
- R7: With `in_signed`=0, a lane's flag is 1 when an add carries out of the lane, or when a subtract does not borrow (minuend >= subtrahend). `out_ge[i]` belongs to byte i (bits 8i+7:8i). A 16-bit lane drives both of its bits: the low lane drives `out_ge[1:0]` and the high lane drives `out_ge[3:2]`.
- R8: With `in_signed`=1, a lane's flag is 1 when the exact two's-complement result, computed without wrapping, is >= 0. The result bits are identical to those produced with `in_signed`=0.
- R9: `out_valid` equals `in_valid` from the previous clock. When `in_valid` was 1, `out_result` and `out_ge` show that cycle's operation.
- R10: When `in_valid` is 0, `out_result` and `out_ge` keep their previous values.
- R11: While synchronous active-high `rst` is asserted, `out_valid`, `out_ge` and `out_result` clear to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands and controls are valid |
| in_a | input | 32 | First operand (minuend for subtracts) |
| in_b | input | 32 | Second operand |
| in_op | input | 2 | 00 add, 01 subtract, 10 exchange add-sub, 11 exchange sub-add |
| in_byte | input | 1 | 1 selects four 8-bit lanes for add/subtract |
| in_signed | input | 1 | 1 selects signed flag semantics |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 32 | Registered lane-wise result |
| out_ge | output | 4 | Registered per-byte greater-or-equal flags |

## Verification
Carry patterns such as 0xFF+0x01 and 0xFFFF+0x0001 separate independent lanes from a single carry chain across the word. Operands with different upper and lower halves separate the exchange pairings from the straight ones, and show whether the add or the subtract lands in the correct half. Equal, larger and smaller subtrahends, together with 0x7F+0x01 and 0x80+0x80 under both sign modes, separate carry/no-borrow flags from sign-based flags. The same tests also confirm that the result bits do not depend on the sign mode. Back-to-back and idle cycles confirm the one-cycle latency and that the outputs hold while no input is valid.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int N_BYTE_LANES = 4;
    localparam int N_HALF_LANES = 2;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_XAS = 2'b10,
        OP_XSA = 2'b11
    } simd_op_e;

    typedef struct packed {
        logic [N_BYTE_LANES-1:0] ge;
        logic                    vld;
    } simd_flags_t;

    // Copy each 16-bit lane flag onto the two byte positions it covers
    function automatic logic [N_BYTE_LANES-1:0] spread_half_ge(input logic [N_HALF_LANES-1:0] hge);
        logic [N_BYTE_LANES-1:0] r;
        for (int i = 0; i < N_HALF_LANES; i++) begin
            r[2*i]   = hge[i];
            r[2*i+1] = hge[i];
        end
        return r;
    endfunction

    // Exchange operations always run on 16-bit lanes
    function automatic logic uses_half_lanes(input simd_op_e op, input logic byte_mode);
        return !byte_mode || op[1];
    endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sgn,
    output logic [W-1:0] res,
    output logic         ge
);
    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] ext_r;

    always_comb begin
        // One extra bit keeps the lane result exact, so it cannot wrap
        ext_a = {sgn & a[W-1], a};
        ext_b = {sgn & b[W-1], b};
        ext_r = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        res   = ext_r[W-1:0];
        if (sgn)      ge = ~ext_r[W];
        else if (sub) ge = ~ext_r[W];
        else          ge = ext_r[W];
    end
endmodule

// File: rtl/simd_operand_route.sv
module simd_operand_route
    import simd_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  simd_op_e                          op,
    input  logic [DATA_W-1:0]                 b,
    output logic [N_HALF_LANES-1:0][HALF_W-1:0] half_b,
    output logic [N_HALF_LANES-1:0]           half_sub,
    output logic                              byte_sub
);
    logic [HALF_W-1:0] b_hi;
    logic [HALF_W-1:0] b_lo;

    always_comb begin
        b_hi     = b[DATA_W-1:HALF_W];
        b_lo     = b[HALF_W-1:0];
        byte_sub = (op == OP_SUB);
        case (op)
            OP_ADD: begin half_b = {b_hi, b_lo}; half_sub = 2'b00; end
            OP_SUB: begin half_b = {b_hi, b_lo}; half_sub = 2'b11; end
            OP_XAS: begin half_b = {b_lo, b_hi}; half_sub = 2'b01; end
            default: begin half_b = {b_lo, b_hi}; half_sub = 2'b10; end
        endcase
    end
endmodule

// File: rtl/simd_pack_adder.sv
module simd_pack_adder
    import simd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [1:0]        in_op,
    input  logic              in_byte,
    input  logic              in_signed,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [N_BYTE_LANES-1:0] out_ge
);
    localparam int HALF_W = DATA_W / N_HALF_LANES;
    localparam int BYTE_W = DATA_W / N_BYTE_LANES;

    simd_op_e op;
    assign op = simd_op_e'(in_op);

    logic [N_HALF_LANES-1:0][HALF_W-1:0] half_b;
    logic [N_HALF_LANES-1:0]             half_sub;
    logic                                byte_sub;

    simd_operand_route #(.DATA_W(DATA_W)) u_route (
        .op       (op),
        .b        (in_b),
        .half_b   (half_b),
        .half_sub (half_sub),
        .byte_sub (byte_sub)
    );

    logic [N_BYTE_LANES-1:0][BYTE_W-1:0] byte_res;
    logic [N_BYTE_LANES-1:0]             byte_ge;
    logic [N_HALF_LANES-1:0][HALF_W-1:0] half_res;
    logic [N_HALF_LANES-1:0]             half_ge;

    for (genvar i = 0; i < N_BYTE_LANES; i++) begin : g_byte
        simd_lane_alu #(.W(BYTE_W)) u_lane (
            .a   (in_a[i*BYTE_W +: BYTE_W]),
            .b   (in_b[i*BYTE_W +: BYTE_W]),
            .sub (byte_sub),
            .sgn (in_signed),
            .res (byte_res[i]),
            .ge  (byte_ge[i])
        );
    end

    for (genvar j = 0; j < N_HALF_LANES; j++) begin : g_half
        simd_lane_alu #(.W(HALF_W)) u_lane (
            .a   (in_a[j*HALF_W +: HALF_W]),
            .b   (half_b[j]),
            .sub (half_sub[j]),
            .sgn (in_signed),
            .res (half_res[j]),
            .ge  (half_ge[j])
        );
    end

    logic [DATA_W-1:0]       nxt_res;
    logic [N_BYTE_LANES-1:0] nxt_ge;

    always_comb begin
        if (uses_half_lanes(op, in_byte)) begin
            nxt_res = half_res;
            nxt_ge  = spread_half_ge(half_ge);
        end else begin
            nxt_res = byte_res;
            nxt_ge  = byte_ge;
        end
    end

    simd_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q    <= '0;
            out_result <= '0;
        end else begin
            flags_q.vld <= in_valid;
            if (in_valid) begin
                flags_q.ge <= nxt_ge;
                out_result <= nxt_res;
            end
        end
    end

    assign out_valid = flags_q.vld;
    assign out_ge    = flags_q.ge;
endmodule

// File: rtl/simd_pack_adder_chk.sv
module simd_pack_adder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [1:0]        in_op,
    input logic              in_byte,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [3:0]        out_ge
);
    localparam int HALF_W = DATA_W / 2;

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_ge)));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && out_ge == 4'b0000 && out_result == '0));

    assert_half_ge_pair_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!in_byte || in_op[1])) |=> (out_ge[0] == out_ge[1] && out_ge[2] == out_ge[3]));

    assert_half_add_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_byte && in_op == 2'b00) |=>
        (out_result[DATA_W-1:HALF_W] == HALF_W'($past(in_a[DATA_W-1:HALF_W]) + $past(in_b[DATA_W-1:HALF_W]))
         && out_result[HALF_W-1:0] == HALF_W'($past(in_a[HALF_W-1:0]) + $past(in_b[HALF_W-1:0]))));

    assert_xchg_addsub_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10) |=>
        (out_result[DATA_W-1:HALF_W] == HALF_W'($past(in_a[DATA_W-1:HALF_W]) + $past(in_b[HALF_W-1:0]))
         && out_result[HALF_W-1:0] == HALF_W'($past(in_a[HALF_W-1:0]) - $past(in_b[DATA_W-1:HALF_W]))));
endmodule

bind simd_pack_adder simd_pack_adder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_op      (in_op),
    .in_byte    (in_byte),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_ge     (out_ge)
);

// File: tb/simd_pack_adder_tb.sv
module simd_pack_adder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_a;
    logic [31:0] in_b;
    logic [1:0]  in_op;
    logic        in_byte;
    logic        in_signed;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_ge;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simd_pack_adder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_op(in_op), .in_byte(in_byte), .in_signed(in_signed),
        .out_valid(out_valid), .out_result(out_result), .out_ge(out_ge)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One lane from the requirements: returns {flag, result}
    function automatic logic [16:0] lane_model(input longint au, input longint bu, input int w,
                                               input bit sub, input bit sgn);
        longint m  = longint'(1) << w;
        longint av = (sgn && au >= m/2) ? au - m : au;
        longint bv = (sgn && bu >= m/2) ? bu - m : bu;
        longint r  = sub ? av - bv : av + bv;
        bit     g  = (sgn || sub) ? (r >= 0) : (r >= m);
        longint rm = ((r % m) + m) % m;
        return {g, 16'(rm)};
    endfunction

    function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] op, input bit byt, input bit sgn);
        logic [31:0] res;
        logic [3:0]  ge;
        logic [16:0] l;
        if (byt && !op[1]) begin
            for (int i = 0; i < 4; i++) begin
                l = lane_model(longint'(a[8*i +: 8]), longint'(b[8*i +: 8]), 8, op[0], sgn);
                res[8*i +: 8] = l[7:0];
                ge[i] = l[16];
            end
        end else begin
            l = lane_model(longint'(a[31:16]), longint'(op[1] ? b[15:0] : b[31:16]), 16,
                           (op == 2'b01) || (op == 2'b11), sgn);
            res[31:16] = l[15:0];
            ge[3:2] = {2{l[16]}};
            l = lane_model(longint'(a[15:0]), longint'(op[1] ? b[31:16] : b[15:0]), 16,
                           (op == 2'b01) || (op == 2'b10), sgn);
            res[15:0] = l[15:0];
            ge[1:0] = {2{l[16]}};
        end
        return {ge, res};
    endfunction

    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] op, input bit byt, input bit sgn);
        logic [35:0] e;
        e = model(a, b, op, byt, sgn);
        @(negedge clk);
        in_a = a; in_b = b; in_op = op; in_byte = byt; in_signed = sgn; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R9 valid"}, {31'b0, out_valid}, 32'd1);
        check({req, " result"}, out_result, e[31:0]);
        check({req, " ge"}, {28'b0, out_ge}, {28'b0, e[35:32]});
    endtask

    task automatic test_reset();
        check("R11 out_valid", {31'b0, out_valid}, 32'd0);
        check("R11 out_ge", {28'b0, out_ge}, 32'd0);
        check("R11 out_result", out_result, 32'd0);
    endtask

    task automatic test_half_add();
        run_op("R1 lane split", 32'h0001_FFFF, 32'h0002_0001, 2'b00, 0, 0);
        run_op("R1 mixed", 32'h1234_8000, 32'hF000_8000, 2'b00, 0, 0);
    endtask

    task automatic test_half_sub();
        run_op("R2 borrow low", 32'h5000_0000, 32'h1000_0001, 2'b01, 0, 0);
        run_op("R2 equal", 32'hABCD_4444, 32'hABCD_4445, 2'b01, 0, 0);
    endtask

    task automatic test_byte_add();
        run_op("R3 carry chain", 32'hFF01_7FFF, 32'h01FF_0101, 2'b00, 1, 0);
        run_op("R3 pattern", 32'h1020_3040, 32'h0F0E_0D0C, 2'b00, 1, 0);
    endtask

    task automatic test_byte_sub();
        run_op("R4 mixed", 32'h0010_FF05, 32'h0120_FF04, 2'b01, 1, 0);
    endtask

    task automatic test_exchange();
        run_op("R5 xas half", 32'h1000_2000, 32'h0003_0005, 2'b10, 0, 0);
        run_op("R5 xas byte sel", 32'hFFFF_0001, 32'h0002_0001, 2'b10, 1, 0);
        run_op("R6 xsa half", 32'h1000_2000, 32'h0003_0005, 2'b11, 0, 0);
        run_op("R6 xsa byte sel", 32'h0000_FFFF, 32'h0001_0001, 2'b11, 1, 0);
    endtask

    task automatic test_flags();
        logic [31:0] r_u;
        run_op("R7 unsigned byte", 32'h7F80_0A05, 32'h0180_0A06, 2'b00, 1, 0);
        r_u = out_result;
        run_op("R8 signed byte", 32'h7F80_0A05, 32'h0180_0A06, 2'b00, 1, 1);
        check("R8 result unaffected by sign", out_result, r_u);
        run_op("R8 signed sub", 32'h8000_7FFF, 32'h0001_FFFF, 2'b01, 0, 1);
        run_op("R7 unsigned sub", 32'h8000_7FFF, 32'h0001_FFFF, 2'b01, 0, 0);
    endtask

    task automatic test_latency_hold();
        logic [35:0] e1;
        logic [35:0] e2;
        e1 = model(32'h0102_0304, 32'h1111_1111, 2'b00, 1, 0);
        e2 = model(32'h9000_0001, 32'h1000_0002, 2'b01, 0, 1);
        @(negedge clk);
        in_a = 32'h0102_0304; in_b = 32'h1111_1111; in_op = 2'b00; in_byte = 1; in_signed = 0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 first result", out_result, e1[31:0]);
        in_a = 32'h9000_0001; in_b = 32'h1000_0002; in_op = 2'b01; in_byte = 0; in_signed = 1;
        @(negedge clk);
        check("R9 second result", out_result, e2[31:0]);
        check("R9 second ge", {28'b0, out_ge}, {28'b0, e2[35:32]});
        in_valid = 1'b0;
        in_a = 32'hFFFF_FFFF; in_b = 32'hFFFF_FFFF; in_op = 2'b00; in_byte = 1; in_signed = 0;
        @(negedge clk);
        check("R9 valid drops", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check("R10 result held", out_result, e2[31:0]);
        check("R10 ge held", {28'b0, out_ge}, {28'b0, e2[35:32]});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_op = '0; in_byte = 0; in_signed = 0;
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        test_half_add();
        test_half_sub();
        test_byte_add();
        test_byte_sub();
        test_exchange();
        test_flags();
        test_latency_hold();
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        test_reset();
        rst = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule